// File: doc/BRIEF.md
# Planar Graphics Data Path Controller

This block sits between a host byte port and a frame store organised as four 8-bit planes. A host read loads all four plane bytes into internal latches and returns either one plane byte or a per-pixel colour-match byte. A host write builds a full 32-bit word, one byte per plane, and presents it to the planes in a single memory cycle. The word is built from the host byte, the latches, a set/reset colour, a logic function and a per-bit mask.

The control settings arrive as plain input ports, which a surrounding register file drives: write mode, read mode, logic function, rotate count, bit mask, set/reset colour, set/reset enables, compare colour, compare care bits and read plane select. Plane p always occupies bits 8p+7 down to 8p of both 32-bit plane buses. Bit n of each byte is pixel n.

Top module: `plane_dp`

## Requirements
- R1: After reset the four plane latches hold zero, plane_we_o is 0 and plane_wdata_o is 0. A read-mode-0 result of plane 0 is therefore 0.
- R2: At a rising edge with host_re_i high, the latches load plane_rdata_i. A write request on host_we_i produces plane_we_o high, together with the full 32-bit plane_wdata_o, in the next cycle. plane_we_o is low in every cycle that follows a cycle without host_we_i.
- R3: Write mode 0 rotates host_data_i right by rot_cnt_i. The logic function is then applied with the plane latch as the second operand. The codes are 0 copy, 1 AND, 2 OR and 3 XOR.
- R4: In write modes 0 and 2, a plane whose sr_enable_i bit is 1 uses its set_reset_i bit, replicated to all 8 pixels, as the source in place of the host value.
- R5: In write modes 0, 2 and 3, each written bit takes the function result where the effective mask bit is 1 and the latch bit where it is 0. In modes 0 and 2 the effective mask is bit_mask_i.
- R6: Write mode 1 writes the four latches unchanged, whatever the function and the mask are.
- R7: Write mode 2 uses bit p of host_data_i, replicated to 8 pixels, as the source for plane p.
- R8: Write mode 3 uses the replicated set_reset_i bit of each plane as the source. Its effective mask is the rotated host byte ANDed with bit_mask_i.
- R9: With rd_mode_i at 0, host_rdata_o is the latch of the plane numbered by rd_map_i.
- R10: With rd_mode_i at 1, bit n of host_rdata_o is 1 when every plane whose cmp_care_i bit is 1 has pixel n equal to its cmp_color_i bit. If no care bit is set, the result is 8'hFF.
- R11: When host_re_i and host_we_i are high in the same cycle, the written word is built from the latch values held before that edge, and the latches then take the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_re_i | input | 1 | Host read: load the latches from plane_rdata_i |
| host_we_i | input | 1 | Host write request |
| host_data_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read result |
| plane_rdata_i | input | 32 | Data read from the four planes |
| plane_we_o | output | 1 | Plane write strobe |
| plane_wdata_o | output | 32 | Data written to the four planes |
| wr_mode_i | input | 2 | Write mode, 0 to 3 |
| rd_mode_i | input | 1 | Read mode: 0 plane select, 1 colour compare |
| alu_fn_i | input | 2 | Logic function: 0 copy, 1 AND, 2 OR, 3 XOR |
| rot_cnt_i | input | 3 | Right-rotate count for the host byte |
| bit_mask_i | input | 8 | Per-pixel write mask |
| set_reset_i | input | 4 | Set/reset colour, one bit per plane |
| sr_enable_i | input | 4 | Set/reset enable, one bit per plane |
| cmp_color_i | input | 4 | Compare colour, one bit per plane |
| cmp_care_i | input | 4 | Compare care bits: 1 means the plane is compared |
| rd_map_i | input | 2 | Plane chosen for read mode 0 |

## Verification
A host read and a host write can fall in the same cycle. In that case the write has to combine the old latch contents while the latches capture new plane data at the same edge. The bench provokes this by asserting host_re_i and host_we_i together in write mode 1, using read data that differs from the current latches. It expects the old latch word on plane_wdata_o in the next cycle. A second mode-1 write must then return the newly read word, which shows that both halves of that edge took effect.

// File: rtl/plane_dp_pkg.sv
package plane_dp_pkg;
  localparam int NPLANES = 4;
  localparam int PLANE_W = 8;

  typedef enum logic [1:0] {
    ALU_COPY = 2'd0,
    ALU_AND  = 2'd1,
    ALU_OR   = 2'd2,
    ALU_XOR  = 2'd3
  } alu_fn_e;

  typedef enum logic [1:0] {
    WM_DIRECT = 2'd0,
    WM_LATCH  = 2'd1,
    WM_SPREAD = 2'd2,
    WM_MASKED = 2'd3
  } wr_mode_e;
endpackage

// File: rtl/plane_dp_latch.sv
module plane_dp_latch #(
  parameter int NP = plane_dp_pkg::NPLANES,
  parameter int PW = plane_dp_pkg::PLANE_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [NP*PW-1:0] d_i,
  output logic [NP*PW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/plane_dp_write.sv
module plane_dp_write
  import plane_dp_pkg::*;
#(
  parameter int NP = NPLANES,
  parameter int PW = PLANE_W,
  localparam int RW = $clog2(PW)
) (
  input  wr_mode_e         mode_i,
  input  alu_fn_e          fn_i,
  input  logic [RW-1:0]    rot_i,
  input  logic [PW-1:0]    mask_i,
  input  logic [NP-1:0]    sr_i,
  input  logic [NP-1:0]    sre_i,
  input  logic [PW-1:0]    host_i,
  input  logic [NP*PW-1:0] latch_i,
  output logic [NP*PW-1:0] wdata_o
);
  logic [2*PW-1:0] dbl;
  logic [PW-1:0]   rot;

  assign dbl = {host_i, host_i} >> rot_i;
  assign rot = dbl[PW-1:0];

  for (genvar p = 0; p < NP; p++) begin : g_plane
    logic [PW-1:0] lat, src, res, msk;
    assign lat = latch_i[p*PW +: PW];

    always_comb begin
      msk = mask_i;
      unique case (mode_i)
        WM_DIRECT: src = sre_i[p] ? {PW{sr_i[p]}} : rot;
        WM_SPREAD: src = sre_i[p] ? {PW{sr_i[p]}} : {PW{host_i[p]}};
        WM_MASKED: begin
          src = {PW{sr_i[p]}};
          msk = rot & mask_i;
        end
        default:   src = lat;
      endcase
      unique case (fn_i)
        ALU_AND: res = src & lat;
        ALU_OR:  res = src | lat;
        ALU_XOR: res = src ^ lat;
        default: res = src;
      endcase
    end

    assign wdata_o[p*PW +: PW] = (mode_i == WM_LATCH) ? lat : ((res & msk) | (lat & ~msk));
  end
endmodule

// File: rtl/plane_dp_read.sv
module plane_dp_read #(
  parameter int NP = plane_dp_pkg::NPLANES,
  parameter int PW = plane_dp_pkg::PLANE_W,
  localparam int MW = $clog2(NP)
) (
  input  logic             mode_i,
  input  logic [MW-1:0]    map_i,
  input  logic [NP-1:0]    color_i,
  input  logic [NP-1:0]    care_i,
  input  logic [NP*PW-1:0] latch_i,
  output logic [PW-1:0]    rdata_o
);
  logic [PW-1:0] sel, cmp;

  assign sel = latch_i[map_i*PW +: PW];

  for (genvar n = 0; n < PW; n++) begin : g_pix
    logic [NP-1:0] miss;
    for (genvar p = 0; p < NP; p++) begin : g_pl
      assign miss[p] = care_i[p] & (latch_i[p*PW + n] ^ color_i[p]);
    end
    assign cmp[n] = ~|miss;
  end

  assign rdata_o = mode_i ? cmp : sel;
endmodule

// File: rtl/plane_dp.sv
module plane_dp
  import plane_dp_pkg::*;
#(
  parameter int NP = NPLANES,
  parameter int PW = PLANE_W,
  localparam int RW = $clog2(PW),
  localparam int MW = $clog2(NP),
  localparam int DW = NP * PW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_re_i,
  input  logic          host_we_i,
  input  logic [PW-1:0] host_data_i,
  output logic [PW-1:0] host_rdata_o,
  input  logic [DW-1:0] plane_rdata_i,
  output logic          plane_we_o,
  output logic [DW-1:0] plane_wdata_o,
  input  logic [1:0]    wr_mode_i,
  input  logic          rd_mode_i,
  input  logic [1:0]    alu_fn_i,
  input  logic [RW-1:0] rot_cnt_i,
  input  logic [PW-1:0] bit_mask_i,
  input  logic [NP-1:0] set_reset_i,
  input  logic [NP-1:0] sr_enable_i,
  input  logic [NP-1:0] cmp_color_i,
  input  logic [NP-1:0] cmp_care_i,
  input  logic [MW-1:0] rd_map_i
);
  logic [DW-1:0] latch_q;
  logic [DW-1:0] wdata_d;

  plane_dp_latch #(.NP(NP), .PW(PW)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (host_re_i),
    .d_i    (plane_rdata_i),
    .q_o    (latch_q)
  );

  plane_dp_write #(.NP(NP), .PW(PW)) u_write (
    .mode_i  (wr_mode_e'(wr_mode_i)),
    .fn_i    (alu_fn_e'(alu_fn_i)),
    .rot_i   (rot_cnt_i),
    .mask_i  (bit_mask_i),
    .sr_i    (set_reset_i),
    .sre_i   (sr_enable_i),
    .host_i  (host_data_i),
    .latch_i (latch_q),
    .wdata_o (wdata_d)
  );

  plane_dp_read #(.NP(NP), .PW(PW)) u_read (
    .mode_i  (rd_mode_i),
    .map_i   (rd_map_i),
    .color_i (cmp_color_i),
    .care_i  (cmp_care_i),
    .latch_i (latch_q),
    .rdata_o (host_rdata_o)
  );

  // write word registered: built from pre-edge latches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      plane_we_o    <= 1'b0;
      plane_wdata_o <= '0;
    end else begin
      plane_we_o <= host_we_i;
      if (host_we_i) plane_wdata_o <= wdata_d;
    end
  end
endmodule

// File: rtl/plane_dp_chk.sv
module plane_dp_chk #(
  parameter int NP = plane_dp_pkg::NPLANES,
  parameter int PW = plane_dp_pkg::PLANE_W,
  localparam int MW = $clog2(NP),
  localparam int DW = NP * PW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          host_re_i,
  input logic          host_we_i,
  input logic [PW-1:0] host_rdata_o,
  input logic [DW-1:0] plane_rdata_i,
  input logic          plane_we_o,
  input logic [DW-1:0] plane_wdata_o,
  input logic [1:0]    wr_mode_i,
  input logic          rd_mode_i,
  input logic [PW-1:0] bit_mask_i,
  input logic [NP-1:0] cmp_care_i,
  input logic [MW-1:0] rd_map_i,
  input logic [DW-1:0] latch_q
);
  assert_we_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_we_i |=> plane_we_o);

  assert_we_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_we_i |=> !plane_we_o);

  assert_latch_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_re_i |=> latch_q == $past(plane_rdata_i));

  assert_latch_copy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && wr_mode_i == 2'd1) |=> plane_wdata_o == $past(latch_q));

  assert_zero_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && wr_mode_i != 2'd3 && bit_mask_i == '0) |=> plane_wdata_o == $past(latch_q));

  assert_plane0_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_re_i && !rd_mode_i && rd_map_i == '0) |=>
      (rd_mode_i || rd_map_i != '0 || host_rdata_o == $past(plane_rdata_i[PW-1:0])));

  assert_no_care_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_mode_i && cmp_care_i == '0) |-> host_rdata_o == '1);
endmodule

bind plane_dp plane_dp_chk #(.NP(NP), .PW(PW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .host_re_i     (host_re_i),
  .host_we_i     (host_we_i),
  .host_rdata_o  (host_rdata_o),
  .plane_rdata_i (plane_rdata_i),
  .plane_we_o    (plane_we_o),
  .plane_wdata_o (plane_wdata_o),
  .wr_mode_i     (wr_mode_i),
  .rd_mode_i     (rd_mode_i),
  .bit_mask_i    (bit_mask_i),
  .cmp_care_i    (cmp_care_i),
  .rd_map_i      (rd_map_i),
  .latch_q       (latch_q)
);

// File: tb/plane_dp_tb.sv
module plane_dp_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_re_i = 1'b0, host_we_i = 1'b0;
  logic [7:0]  host_data_i = '0;
  logic [7:0]  host_rdata_o;
  logic [31:0] plane_rdata_i = '0;
  logic        plane_we_o;
  logic [31:0] plane_wdata_o;
  logic [1:0]  wr_mode_i = '0, alu_fn_i = '0, rd_map_i = '0;
  logic        rd_mode_i = 1'b0;
  logic [2:0]  rot_cnt_i = '0;
  logic [7:0]  bit_mask_i = 8'hFF;
  logic [3:0]  set_reset_i = '0, sr_enable_i = '0, cmp_color_i = '0, cmp_care_i = '0;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  plane_dp u_dut (.*);

  typedef struct packed {
    logic [1:0]  wm;
    logic [1:0]  fn;
    logic [2:0]  rot;
    logic [7:0]  mask;
    logic [3:0]  sr;
    logic [3:0]  sre;
    logic [7:0]  host;
    logic [31:0] exp;
  } vec_t;

  // latches hold 32'hF0CCAA0F for every vector
  localparam vec_t VECS [8] = '{
    '{2'd0, 2'd0, 3'd0, 8'hFF, 4'h0, 4'h0, 8'h5A, 32'h5A5A5A5A},  // R3 copy
    '{2'd0, 2'd3, 3'd0, 8'hFF, 4'h0, 4'h0, 8'hFF, 32'h0F3355F0},  // R3 xor
    '{2'd0, 2'd0, 3'd4, 8'h0F, 4'h0, 4'h0, 8'h12, 32'hF1C1A101},  // R5 mask
    '{2'd0, 2'd0, 3'd0, 8'hFF, 4'h1, 4'h5, 8'h3C, 32'h3C003CFF},  // R4
    '{2'd1, 2'd3, 3'd0, 8'h00, 4'h0, 4'h0, 8'hFF, 32'hF0CCAA0F},  // R6
    '{2'd2, 2'd1, 3'd0, 8'hFF, 4'h0, 4'h0, 8'h06, 32'h00CCAA00},  // R7
    '{2'd3, 2'd0, 3'd0, 8'h3C, 4'hA, 4'h0, 8'hF0, 32'hF0CCBA0F},  // R8
    '{2'd0, 2'd2, 3'd1, 8'hFF, 4'h0, 4'h0, 8'h01, 32'hF0CCAA8F}   // R3 or
  };
  localparam string VTAG [8] = '{"R3", "R3", "R5", "R4", "R6", "R7", "R8", "R3"};

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic do_read(input logic [31:0] d);
    @(negedge clk_i);
    host_re_i = 1'b1; plane_rdata_i = d;
    @(negedge clk_i);
    host_re_i = 1'b0;
  endtask

  task automatic do_write(input vec_t v);
    @(negedge clk_i);
    wr_mode_i = v.wm; alu_fn_i = v.fn; rot_cnt_i = v.rot; bit_mask_i = v.mask;
    set_reset_i = v.sr; sr_enable_i = v.sre; host_data_i = v.host; host_we_i = 1'b1;
    @(negedge clk_i);
    host_we_i = 1'b0;
  endtask

  task automatic read_out(input logic mode, input logic [1:0] map,
                          input logic [3:0] col, input logic [3:0] care);
    rd_mode_i = mode; rd_map_i = map; cmp_color_i = col; cmp_care_i = care;
    #1;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    vec_t lc;
    lc = '{2'd1, 2'd0, 3'd0, 8'hFF, 4'h0, 4'h0, 8'h00, 32'h0};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 we", {31'd0, plane_we_o}, 32'd0);
    check("R1 wdata", plane_wdata_o, 32'd0);
    read_out(1'b0, 2'd0, 4'h0, 4'h0);
    check("R1 rdata", {24'd0, host_rdata_o}, 32'd0);
    do_write(lc);
    check("R1 latch zero", plane_wdata_o, 32'd0);
    check("R2 we strobe", {31'd0, plane_we_o}, 32'd1);
    @(negedge clk_i);
    check("R2 we idle", {31'd0, plane_we_o}, 32'd0);

    do_read(32'hF0CCAA0F);
    for (int i = 0; i < 8; i++) begin
      do_write(VECS[i]);
      check(VTAG[i], plane_wdata_o, VECS[i].exp);
    end

    // R9 plane select
    read_out(1'b0, 2'd0, 4'h0, 4'h0); check("R9 map0", {24'd0, host_rdata_o}, 32'h0F);
    read_out(1'b0, 2'd1, 4'h0, 4'h0); check("R9 map1", {24'd0, host_rdata_o}, 32'hAA);
    read_out(1'b0, 2'd2, 4'h0, 4'h0); check("R9 map2", {24'd0, host_rdata_o}, 32'hCC);
    read_out(1'b0, 2'd3, 4'h0, 4'h0); check("R9 map3", {24'd0, host_rdata_o}, 32'hF0);
    // R10 compare
    read_out(1'b1, 2'd0, 4'h0, 4'hF); check("R10 all0", {24'd0, host_rdata_o}, 32'h00);
    read_out(1'b1, 2'd0, 4'h0, 4'h3); check("R10 care03", {24'd0, host_rdata_o}, 32'h50);
    read_out(1'b1, 2'd0, 4'h5, 4'h0); check("R10 nocare", {24'd0, host_rdata_o}, 32'hFF);
    read_out(1'b1, 2'd0, 4'h5, 4'hF); check("R10 col5", {24'd0, host_rdata_o}, 32'h04);
    read_out(1'b1, 2'd0, 4'hF, 4'hF); check("R10 colF", {24'd0, host_rdata_o}, 32'h00);
    read_out(1'b0, 2'd0, 4'h0, 4'h0);

    // R11 read and write on the same edge
    @(negedge clk_i);
    wr_mode_i = 2'd1; host_we_i = 1'b1; host_re_i = 1'b1; plane_rdata_i = 32'h11223344;
    @(negedge clk_i);
    host_we_i = 1'b0; host_re_i = 1'b0;
    check("R11 old latch", plane_wdata_o, 32'hF0CCAA0F);
    do_write(lc);
    check("R11 new latch", plane_wdata_o, 32'h11223344);
    // R2 latch load visible on the read port
    check("R2 read load", {24'd0, host_rdata_o}, 32'h44);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule